// File: doc/BRIEF.md
# Dual-Rail Precharged Evaluation Stage

This block is one pipeline stage of a dual-rail datapath. A single-rail operand `din` is split at the stage boundary into a true rail and a false rail per bit. A second operand arrives already in dual-rail form from an upstream stage. Both operands feed a small function built only from AND and OR gates on the rails. The true output of each bit is formed from the function, and the false output from its dual. The true and false networks never feed each other, and no inversion happens after the boundary encoder.

The `eval` input selects the phase. While it is low (precharge), every combinational rail is held at 0. While it is high (evaluation), data flows through the network. The stage's registers load only on a clock edge that closes an evaluation cycle, and they keep their value through the next precharge. A registered error flag reports any upstream pair that is not a legal code, and any network output pair that is not one-hot.

A parameter selects the function. One variant is an AND/OR mixing network. The other is a 4-bit substitution-box slice applied to the XOR of the two operands, built as a full minterm decode.

Top module: `dpr_stage`

## Requirements
- R1: While reset is asserted and after it is released, `dout` is 0 and `err` is 0 until the first evaluation capture.
- R2: Whenever `eval` is 0, every bit of `net_t` and `net_f` is 0, whatever the values on `din`, `up_t` and `up_f`.
- R3: Rail codes are read as (true, false): 10 is logic 1, 01 is logic 0, 00 is null and 11 is illegal. During evaluation with every upstream pair legal, each output pair `{net_t[i], net_f[i]}` is exactly one-hot.
- R4: In the AND/OR variant (FN = DPR_FN_ANDOR), with a = `din`, b = `up_t` and j = (i+1) mod W, the true value of bit i is (a[i] & b[i]) | (a[j] & ~b[j]).
- R5: In the substitution variant (FN = DPR_FN_SBOX, W = 4), the true value is S(a ^ b). The table maps 0..15 to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 (hexadecimal).
- R6: On a rising clock edge where `eval` is 1, the stage captures the network rails, and `dout` then shows the decoded true values. On an edge where `eval` is 0, `dout` and `err` keep their values.
- R7: At each capture, `err` is set to 1 if any upstream pair is 00 or 11 or any output pair is not one-hot. Otherwise it is set to 0, so a following legal capture clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval | input | 1 | Phase select: 1 evaluate, 0 precharge |
| din | input | W | Single-rail operand, encoded at the boundary |
| up_t | input | W | Upstream operand, true rails |
| up_f | input | W | Upstream operand, false rails |
| net_t | output | W | Network output, true rails (combinational) |
| net_f | output | W | Network output, false rails (combinational) |
| dout | output | W | Registered result, decoded to single-rail |
| err | output | 1 | Registered rail-validity error |

## Verification
The bench runs every combination of both operands through both function variants, one precharge and one evaluation cycle per combination. In each precharge it drives live data on the inputs. A stage whose rails are not forced to zero in that phase would show nonzero rails, and a stage whose registers load in precharge would change `dout` before the next evaluation edge. It injects a 11 pair and then a 00 pair on the upstream operand, each followed by a clean vector. A flag that misses either code, or that sticks after a clean capture, is caught at the port. A network whose false rail is not the exact dual of its true rail shows either a pair that is not one-hot or a wrong decoded value.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   typedef enum logic [0:0] {
      DPR_FN_ANDOR = 1'b0,
      DPR_FN_SBOX  = 1'b1
   } dpr_fn_e;

   // rail pair codes, {true, false}
   localparam logic [1:0] DPR_NULL = 2'b00;
   localparam logic [1:0] DPR_ZERO = 2'b01;
   localparam logic [1:0] DPR_ONE  = 2'b10;
   localparam logic [1:0] DPR_BAD  = 2'b11;

endpackage

// File: rtl/dpr_front.sv
// Boundary encoder and phase gating: every rail leaving here is 0 in precharge.
module dpr_front #(
   parameter int W = 4
) (
   input  logic         eval,
   input  logic [W-1:0] din,
   input  logic [W-1:0] up_t,
   input  logic [W-1:0] up_f,
   output logic [W-1:0] a_t,
   output logic [W-1:0] a_f,
   output logic [W-1:0] b_t,
   output logic [W-1:0] b_f
);
   logic [W-1:0] ph;

   assign ph = {W{eval}};

   for (genvar i = 0; i < W; i++) begin : g_bit
      // single-rail inversion happens only here, at the boundary
      assign a_t[i] = ph[i] & din[i];
      assign a_f[i] = ph[i] & ~din[i];
      assign b_t[i] = ph[i] & up_t[i];
      assign b_f[i] = ph[i] & up_f[i];
   end
endmodule

// File: rtl/dpr_valid.sv
// Reports whether every rail pair of a vector is exactly one-hot.
module dpr_valid #(
   parameter int W = 4
) (
   input  logic [W-1:0] rt,
   input  logic [W-1:0] rf,
   output logic         all_ok
);
   logic [W-1:0] pair_ok;

   for (genvar i = 0; i < W; i++) begin : g_pair
      assign pair_ok[i] = ({rt[i], rf[i]} == dpr_pkg::DPR_ONE) ||
                          ({rt[i], rf[i]} == dpr_pkg::DPR_ZERO);
   end

   assign all_ok = &pair_ok;
endmodule

// File: rtl/dpr_logic.sv
// Monotonic dual-rail function: the true network computes f, the false network its dual.
module dpr_logic #(
   parameter int                W   = 4,
   parameter dpr_pkg::dpr_fn_e  FN  = dpr_pkg::DPR_FN_ANDOR,
   parameter logic [W*(2**W)-1:0] TBL = '0
) (
   input  logic [W-1:0] a_t,
   input  logic [W-1:0] a_f,
   input  logic [W-1:0] b_t,
   input  logic [W-1:0] b_f,
   output logic [W-1:0] y_t,
   output logic [W-1:0] y_f
);
   localparam int NM = 2**W;

   if (FN == dpr_pkg::DPR_FN_ANDOR) begin : g_andor
      for (genvar i = 0; i < W; i++) begin : g_bit
         localparam int J = (i + 1) % W;
         assign y_t[i] = (a_t[i] & b_t[i]) | (a_t[J] & b_f[J]);
         assign y_f[i] = (a_f[i] | b_f[i]) & (a_f[J] | b_t[J]);
      end
   end else begin : g_sbox
      logic [W-1:0]  x_t;
      logic [W-1:0]  x_f;
      logic [NM-1:0] mt;

      // dual-rail XOR from monotonic terms
      for (genvar k = 0; k < W; k++) begin : g_xor
         assign x_t[k] = (a_t[k] & b_f[k]) | (a_f[k] & b_t[k]);
         assign x_f[k] = (a_t[k] & b_t[k]) | (a_f[k] & b_f[k]);
      end

      // full minterm decode: exactly one minterm is high in evaluation
      for (genvar m = 0; m < NM; m++) begin : g_mt
         logic [W-1:0] lit;
         for (genvar k = 0; k < W; k++) begin : g_lit
            if (((m >> k) & 1) == 1) begin : g_hi
               assign lit[k] = x_t[k];
            end else begin : g_lo
               assign lit[k] = x_f[k];
            end
         end
         assign mt[m] = &lit;
      end

      always_comb begin
         y_t = '0;
         y_f = '0;
         for (int m = 0; m < NM; m++) begin
            for (int o = 0; o < W; o++) begin
               if (TBL[m*W + o]) y_t[o] = y_t[o] | mt[m];
               else              y_f[o] = y_f[o] | mt[m];
            end
         end
      end
   end
endmodule

// File: rtl/dpr_stage.sv
module dpr_stage #(
   parameter int                  W        = 4,
   parameter dpr_pkg::dpr_fn_e    FN       = dpr_pkg::DPR_FN_ANDOR,
   parameter logic [W*(2**W)-1:0] SBOX_TBL = 64'h21748FE3DA09B65C
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         eval,
   input  logic [W-1:0] din,
   input  logic [W-1:0] up_t,
   input  logic [W-1:0] up_f,
   output logic [W-1:0] net_t,
   output logic [W-1:0] net_f,
   output logic [W-1:0] dout,
   output logic         err
);
   // elaboration-time parameter checks
   if (W < 2) begin : g_chk_w
      $error("dpr_stage: W must be at least 2");
   end
   if (FN == dpr_pkg::DPR_FN_SBOX && W > 6) begin : g_chk_sbox
      $error("dpr_stage: substitution variant limited to W <= 6");
   end

   logic [W-1:0] a_t, a_f, b_t, b_f;
   logic [W-1:0] y_t, y_f;
   logic         b_ok, y_ok;
   logic [W-1:0] q_t, q_f;
   logic         err_q;

   dpr_front #(.W(W)) u_front (
      .eval (eval),
      .din  (din),
      .up_t (up_t),
      .up_f (up_f),
      .a_t  (a_t),
      .a_f  (a_f),
      .b_t  (b_t),
      .b_f  (b_f)
   );

   dpr_logic #(.W(W), .FN(FN), .TBL(SBOX_TBL)) u_logic (
      .a_t (a_t),
      .a_f (a_f),
      .b_t (b_t),
      .b_f (b_f),
      .y_t (y_t),
      .y_f (y_f)
   );

   dpr_valid #(.W(W)) u_chk_in (
      .rt     (b_t),
      .rf     (b_f),
      .all_ok (b_ok)
   );

   dpr_valid #(.W(W)) u_chk_out (
      .rt     (y_t),
      .rf     (y_f),
      .all_ok (y_ok)
   );

   // capture only on the edge that closes an evaluation cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_t   <= '0;
         q_f   <= '0;
         err_q <= 1'b0;
      end else if (eval) begin
         q_t   <= y_t;
         q_f   <= y_f;
         err_q <= ~(b_ok & y_ok);
      end
   end

   assign net_t = y_t;
   assign net_f = y_f;
   assign dout  = q_t & ~q_f;   // only the 10 code decodes to 1
   assign err   = err_q;
endmodule

// File: rtl/dpr_stage_sva.sv
module dpr_stage_sva #(
   parameter int W = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         eval,
   input logic [W-1:0] up_t,
   input logic [W-1:0] up_f,
   input logic [W-1:0] net_t,
   input logic [W-1:0] net_f,
   input logic [W-1:0] dout,
   input logic         err
);
   logic up_legal;
   assign up_legal = ((up_t ^ up_f) == {W{1'b1}});

   assert_precharge_null_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !eval |-> (net_t == '0) && (net_f == '0));

   assert_eval_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && up_legal) |-> (((net_t ^ net_f) == {W{1'b1}}) && ((net_t & net_f) == '0)));

   assert_capture_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eval |=> (dout == $past(net_t & ~net_f)));

   assert_precharge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !eval |=> ($stable(dout) && $stable(err)));

   assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !up_legal) |=> err);

   assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && up_legal) |=> !err);
endmodule

bind dpr_stage dpr_stage_sva #(.W(W)) u_sva (.*);

// File: tb/tb_dpr_stage.sv
`timescale 1ns/1ps
module tb_dpr_stage;
   localparam int W = 4;

   typedef struct {
      logic [W-1:0] y_a;
      logic [W-1:0] y_s;
      logic         e;
      logic         data_ok;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         eval = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] up_t = '0;
   logic [W-1:0] up_f = '0;

   logic [W-1:0] net_t_a, net_f_a, dout_a;
   logic [W-1:0] net_t_s, net_f_s, dout_s;
   logic         err_a, err_s;

   exp_t   sb_q[$];
   int     n_checks = 0;
   int     n_fail   = 0;
   logic   cap_seen = 1'b0;
   logic [W-1:0] last_a = '0, last_s = '0;
   logic   last_e = 1'b0;
   logic   last_data_ok = 1'b1;

   always #10 clk = ~clk;   // 50 MHz

   dpr_stage #(.W(W), .FN(dpr_pkg::DPR_FN_ANDOR)) dut (
      .clk(clk), .rst_n(rst_n), .eval(eval), .din(din), .up_t(up_t), .up_f(up_f),
      .net_t(net_t_a), .net_f(net_f_a), .dout(dout_a), .err(err_a));

   dpr_stage #(.W(W), .FN(dpr_pkg::DPR_FN_SBOX)) dut_sb (
      .clk(clk), .rst_n(rst_n), .eval(eval), .din(din), .up_t(up_t), .up_f(up_f),
      .net_t(net_t_s), .net_f(net_f_s), .dout(dout_s), .err(err_s));

   task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] ref_andor(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] y;
      for (int i = 0; i < W; i++) begin
         y[i] = (a[i] & b[i]) | (a[(i+1)%W] & ~b[(i+1)%W]);
      end
      return y;
   endfunction

   function automatic logic [3:0] ref_sbox(input logic [3:0] x);
      case (x)
         4'h0: return 4'hC;  4'h1: return 4'h5;  4'h2: return 4'h6;  4'h3: return 4'hB;
         4'h4: return 4'h9;  4'h5: return 4'h0;  4'h6: return 4'hA;  4'h7: return 4'hD;
         4'h8: return 4'h3;  4'h9: return 4'hE;  4'hA: return 4'hF;  4'hB: return 4'h8;
         4'hC: return 4'h4;  4'hD: return 4'h7;  4'hE: return 4'h1;  default: return 4'h2;
      endcase
   endfunction

   // driver: one precharge cycle then one evaluation cycle
   task automatic run_pair(input logic [W-1:0] a, input logic [W-1:0] bt, input logic [W-1:0] bf);
      exp_t it;
      bit legal;
      legal = ((bt ^ bf) == {W{1'b1}});
      @(negedge clk);
      eval = 1'b0; din = a; up_t = bt; up_f = bf;   // live data during precharge
      #2;
      check((net_t_a | net_f_a) == '0, "R2 andor rails in precharge", {net_t_a, net_f_a}, 8'h00);
      check((net_t_s | net_f_s) == '0, "R2 sbox rails in precharge", {net_t_s, net_f_s}, 8'h00);
      check(err_a == last_e && err_s == last_e, "R6 err held in precharge", {err_a, err_s}, {last_e, last_e});
      if (last_data_ok) begin
         check(dout_a == last_a, "R6 andor dout held in precharge", dout_a, last_a);
         check(dout_s == last_s, "R6 sbox dout held in precharge", dout_s, last_s);
      end
      @(negedge clk);
      eval = 1'b1;
      #2;
      if (last_data_ok) begin
         check(dout_a == last_a, "R6 andor dout unchanged by precharge edge", dout_a, last_a);
      end
      if (legal) begin
         check(((net_t_a ^ net_f_a) == 4'hF) && ((net_t_a & net_f_a) == 4'h0),
               "R3 andor pairs one-hot", {net_t_a, net_f_a}, {ref_andor(a, bt), ~ref_andor(a, bt)});
         check(((net_t_s ^ net_f_s) == 4'hF) && ((net_t_s & net_f_s) == 4'h0),
               "R3 sbox pairs one-hot", {net_t_s, net_f_s}, {ref_sbox(a ^ bt), ~ref_sbox(a ^ bt)});
         check(net_t_a == ref_andor(a, bt), "R4 andor function", net_t_a, ref_andor(a, bt));
         check(net_t_s == ref_sbox(a ^ bt), "R5 sbox function", net_t_s, ref_sbox(a ^ bt));
      end
      it.y_a = ref_andor(a, bt);
      it.y_s = ref_sbox(a ^ bt);
      it.e = !legal;
      it.data_ok = legal;
      sb_q.push_back(it);
   endtask

   // monitor
   always @(posedge clk) cap_seen <= eval;

   always @(negedge clk) begin
      if (rst_n && cap_seen) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R6 capture without pending item", 8'h1, 8'h0);
         end else begin
            exp_t it;
            it = sb_q.pop_front();
            check(err_a == it.e, "R7 andor err after capture", err_a, it.e);
            check(err_s == it.e, "R7 sbox err after capture", err_s, it.e);
            if (it.data_ok) begin
               check(dout_a == it.y_a, "R6 andor captured dout", dout_a, it.y_a);
               check(dout_s == it.y_s, "R6 sbox captured dout", dout_s, it.y_s);
               last_a = it.y_a;
               last_s = it.y_s;
            end else begin
               last_a = dout_a;
               last_s = dout_s;
            end
            last_e = it.e;
            last_data_ok = 1'b1;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(dout_a == '0 && dout_s == '0, "R1 dout in reset", {dout_a, dout_s}, 8'h00);
      check(err_a == 1'b0 && err_s == 1'b0, "R1 err in reset", {err_a, err_s}, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #2;
      check(dout_a == '0 && dout_s == '0, "R1 dout after reset", {dout_a, dout_s}, 8'h00);
      check(err_a == 1'b0 && err_s == 1'b0, "R1 err after reset", {err_a, err_s}, 8'h00);

      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            run_pair(4'(a), 4'(b), ~4'(b));
         end
      end
      // R7: illegal 11 pair on bit 2, then a clean vector clears the flag
      run_pair(4'h6, 4'b0111, 4'b1100);
      run_pair(4'h6, 4'b0011, 4'b1100);
      // R7: null 00 pair on bit 0 during evaluation, then a clean vector
      run_pair(4'h9, 4'b0010, 4'b1100);
      run_pair(4'h9, 4'b1010, 4'b0101);

      @(negedge clk);
      eval = 1'b0;
      repeat (2) @(negedge clk);
      check(sb_q.size() == 0, "R6 every evaluation captured", 8'(sb_q.size()), 8'h0);
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end
endmodule